// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets on-chip logic read and write the registers of an Ethernet PHY over the two-wire management interface. A requester presents a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data, then pulses `start`. The block builds the whole management frame and shifts it out MSB first on `mdio_out`, with `mdio_oe` controlling the external tristate buffer. It paces `mdc` from the system clock and collects read data from `mdio_in`. The requester then gets a single-cycle `done` and, for reads, the register value on `rd_data`.

Each serial bit takes one MDC period. The period has a low phase followed by a high phase, and each phase lasts `HALF_DIV` system clocks. The next bit is placed on `mdio_out` at the start of the low phase, so it is set up a full half-period before the rising edge. On reads, `mdio_in` is sampled one system clock after MDC goes high.

A four-state machine sequences the frame. Its states are ST_IDLE (waiting), ST_LOW (MDC low phase), ST_HIGH (MDC high phase) and ST_FIN (done cycle). The transitions are:
- ST_IDLE to ST_LOW when a request is accepted.
- ST_LOW to ST_HIGH when the half-period expires.
- ST_HIGH to ST_LOW when the half-period expires and more bits remain.
- ST_HIGH to ST_FIN when the half-period of the final bit expires.
- ST_FIN to ST_IDLE on the next clock.

Top module: `mdio_frame_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles in which `mdio_out` is 1 and `mdio_oe` is 1.
- R2: The preamble is followed by the start pattern 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address and then the 5-bit register address. Each field is sent MSB first with `mdio_oe` high.
- R3: A write continues with 1,0 and then the 16 data bits MSB first, which makes 64 MDC cycles in all, all driven. `mdio_oe` is low from the `done` cycle onward.
- R4: A read drops `mdio_oe` after the register address, leaving 46 driven cycles. It then runs 17 sampled MDC cycles and 2 further cycles whose `mdio_in` value is ignored, which makes 65 MDC cycles in all. The first sample is discarded, and the other 16 form `rd_data` with the earliest sample as bit 15.
- R5: Each MDC high phase and each low phase within a frame lasts exactly `HALF_DIV` system clocks. `mdio_out` changes only while MDC is low, so every bit is stable at the rising edge.
- R6: `mdio_in` is sampled one system clock after MDC rises. A PHY that changes its output at the rising edge therefore delivers the value it presented for that cycle.
- R7: `busy` is high from the clock after a request is accepted until `done`. A `start` pulse while `busy` is high is ignored and does not alter the running frame or launch a new one.
- R8: `done` is high for exactly one system clock per frame, and `rd_data` holds the read result in that cycle.
- R9: After reset and while idle, `mdc` is 0, `mdio_oe` is 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data to the tristate buffer |
| mdio_oe | output | 1 | Tristate enable for `mdio_out` |
| mdio_in | input | 1 | Serial data from the pad |

## Verification
The assertions assume that `start` is a synchronous level that matters only in ST_IDLE. They also assume that request fields need to be valid only in the accepting cycle and that `mdio_in` is an already-synchronised signal. The bench drives every input on the falling system clock, keeps `start` high for one cycle, and holds the request fields constant while the frame runs. An exception is the deliberate overlapping request used to exercise R7. Its PHY model changes `mdio_in` only at MDC rising edges. Outside the sampled window it drives ones, so that a stray sample shows up as corrupted read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_FIN  = 2'd3
    } mdio_state_t;

    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 14;                  // start, opcode, two addresses
    localparam int DRV_RD    = PRE_LEN + HDR_LEN;   // driven cycles of a read
    localparam int DATA_LEN  = 16;
    localparam int TA_LEN    = 2;
    localparam int FRAME_W   = DRV_RD + TA_LEN + DATA_LEN;
    localparam int RX_SLOTS  = DATA_LEN + 1;
    localparam int TAIL_LEN  = 2;
    localparam int LEN_RD    = DRV_RD + RX_SLOTS + TAIL_LEN;
    localparam int LEN_WR    = FRAME_W;
    localparam int IDX_W     = $clog2(LEN_RD + 1);

endpackage

// File: rtl/mdc_pacer.sv
module mdc_pacer #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic phase_first
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick        = run && (cnt == LAST);
    assign phase_first = run && (cnt == '0);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clear) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {data[WIDTH-2:0], din};
        end
    end

    p_no_shift_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (data == '0));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam logic [IDX_W-1:0] LAST_RD  = IDX_W'(LEN_RD - 1);
    localparam logic [IDX_W-1:0] LAST_WR  = IDX_W'(LEN_WR - 1);
    localparam logic [IDX_W-1:0] RX_LO    = IDX_W'(DRV_RD);
    localparam logic [IDX_W-1:0] RX_HI    = IDX_W'(DRV_RD + RX_SLOTS - 1);
    localparam logic [IDX_W-1:0] DRV_RD_I = IDX_W'(DRV_RD);
    localparam logic [IDX_W-1:0] DRV_WR_I = IDX_W'(LEN_WR);

    mdio_state_t        state, state_nx;
    logic [FRAME_W-1:0] tx_sr;
    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   idx_nx;
    logic               is_read;
    logic               mdc_q, mdo_q, oe_q;
    logic               tick, phase_first;
    logic               last_bit, accept, rx_en;
    logic [FRAME_W-1:0] frame;

    mdc_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state == ST_LOW || state == ST_HIGH),
        .tick        (tick),
        .phase_first (phase_first)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign last_bit = bit_idx == (is_read ? LAST_RD : LAST_WR);
    assign idx_nx   = bit_idx + 1'b1;
    assign rx_en    = (state == ST_HIGH) && phase_first && is_read &&
                      (bit_idx >= RX_LO) && (bit_idx <= RX_HI);
    assign frame    = {{PRE_LEN{1'b1}}, 2'b01, (rd_nwr ? 2'b10 : 2'b01),
                       phy_addr, reg_addr, 2'b10, wr_data};

    mdio_rx_shift #(.WIDTH(DATA_LEN)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (rx_en),
        .din      (mdio_in),
        .data     (rd_data)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOW;
            ST_LOW:  if (tick)  state_nx = ST_HIGH;
            ST_HIGH: if (tick)  state_nx = last_bit ? ST_FIN : ST_LOW;
            ST_FIN:             state_nx = ST_IDLE;
            default:            state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            bit_idx <= '0;
            is_read <= 1'b0;
            mdc_q   <= 1'b0;
            mdo_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        tx_sr   <= frame;
                        is_read <= rd_nwr;
                        bit_idx <= '0;
                        mdo_q   <= frame[FRAME_W-1];
                        oe_q    <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tick) mdc_q <= 1'b1;
                end
                ST_HIGH: begin
                    if (tick) begin
                        mdc_q <= 1'b0;
                        if (last_bit) begin
                            oe_q  <= 1'b0;
                            mdo_q <= 1'b0;
                        end else begin
                            bit_idx <= idx_nx;
                            tx_sr   <= tx_sr << 1;
                            mdo_q   <= tx_sr[FRAME_W-2];
                            oe_q    <= oe_q && (idx_nx < (is_read ? DRV_RD_I : DRV_WR_I));
                        end
                    end
                end
                ST_FIN: begin
                    mdo_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign mdc      = mdc_q;
    assign mdio_out = mdo_q;
    assign mdio_oe  = oe_q;

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mdc_q && !oe_q));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mdc_paced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mdc_q));

    p_mdo_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q && !tick) |=> $stable(mdo_q));

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && busy && bit_idx >= DRV_RD_I) |-> !oe_q);

    p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(is_read));

endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int HALF = 3;
    localparam int NVEC = 6;
    // {read, phy, reg, write data, data returned by the PHY model}
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000},
        {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
        {1'b0, 5'h05, 5'h0A, 16'hA5C3, 16'h0000},
        {1'b1, 5'h00, 5'h01, 16'h0000, 16'h7A10},
        {1'b1, 5'h1F, 5'h12, 16'h0000, 16'h8001},
        {1'b1, 5'h15, 5'h0A, 16'h0000, 16'hFFFF}
    };

    logic clk = 0, rst_n = 0, start = 0, rd_nwr = 0, mdio_in = 1;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic busy, done, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_frame_master #(.HALF_DIV(HALF)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: records each rising MDC edge and presents read data
    logic [79:0] cap_out, cap_oe;
    int rise_n = 0;
    logic [15:0] phy_rd = '0;

    always @(posedge mdc) begin
        if (rise_n < 80) begin
            cap_out[79-rise_n] = mdio_out;
            cap_oe[79-rise_n]  = mdio_oe;
        end
        if (rise_n == 46)                     mdio_in = 1'b0;
        else if (rise_n >= 47 && rise_n <= 62) mdio_in = phy_rd[15-(rise_n-47)];
        else                                  mdio_in = 1'b1;
        rise_n = rise_n + 1;
    end

    // phase length and data stability monitor
    logic mdc_prev = 0, mdo_prev = 0, after_fall = 0;
    int run_len = 0, hi_bad = 0, lo_bad = 0, mdo_bad = 0;

    always @(negedge clk) begin
        if (mdc == mdc_prev) begin
            run_len++;
        end else begin
            if (mdc_prev && run_len != HALF) hi_bad++;
            if (!mdc_prev && after_fall && run_len != HALF) lo_bad++;
            if (mdc_prev) after_fall = 1;
            run_len = 1;
        end
        if (mdc && mdc_prev && mdio_oe && mdio_out != mdo_prev) mdo_bad++;
        mdc_prev = mdc;
        mdo_prev = mdio_out;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    logic [15:0] got_rd;
    int done_len;

    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] prd,
                             input bit poke_busy);
        int waited;
        @(negedge clk);
        rise_n = 0; after_fall = 0; hi_bad = 0; lo_bad = 0; mdo_bad = 0;
        phy_rd = prd;
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
        if (poke_busy) begin
            repeat (50) @(negedge clk);
            rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1;
            @(negedge clk);
            start = 0;
            rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        got_rd = rd_data;
        done_len = done ? 1 : 0;
        @(negedge clk);
        if (done) done_len++;
        check(done_len == 1, "R8 done width", 64'(done_len), 64'd1);
    endtask

    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=expired expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [63:0] exp_f, cap_f;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0, "R9 reset state",
              64'({mdc, mdio_oe, busy, done}), 64'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(mdc == 0 && mdio_oe == 0, "R9 idle pins", 64'({mdc, mdio_oe}), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic rd;
            logic [4:0] pa, ra;
            logic [15:0] wd, prd;
            {rd, pa, ra, wd, prd} = VEC[i];
            run_frame(rd, pa, ra, wd, prd, 1'b0);
            exp_f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
            cap_f = cap_out[79:16];
            check(cap_f[63:32] == 32'hFFFF_FFFF && cap_oe[79:48] == '1, "R1 preamble",
                  64'(cap_f[63:32]), 64'hFFFF_FFFF);
            check(cap_f[31:18] == exp_f[31:18], "R2 header", 64'(cap_f[31:18]),
                  64'(exp_f[31:18]));
            check(hi_bad == 0 && lo_bad == 0, "R5 half periods",
                  64'(hi_bad + lo_bad), 64'd0);
            check(mdo_bad == 0, "R5 data stable while high", 64'(mdo_bad), 64'd0);
            check(mdio_oe == 0 && mdc == 0, "R9 idle after frame",
                  64'({mdio_oe, mdc}), 64'd0);
            if (rd) begin
                check(rise_n == 65, "R4 read length", 64'(rise_n), 64'd65);
                check($countones(cap_oe[79:15]) == 46 && cap_oe[79:34] == '1,
                      "R4 release after address", 64'($countones(cap_oe[79:15])), 64'd46);
                check(got_rd == prd, "R4 R6 read data", 64'(got_rd), 64'(prd));
            end else begin
                check(rise_n == 64, "R3 write length", 64'(rise_n), 64'd64);
                check(cap_f[17:0] == exp_f[17:0] && cap_oe[79:16] == '1,
                      "R3 turnaround and data", 64'(cap_f[17:0]), 64'(exp_f[17:0]));
            end
        end

        // R7 request during a write frame must be ignored
        run_frame(1'b0, 5'h0C, 5'h03, 16'h1234, 16'h0000, 1'b1);
        exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'h1234};
        check(cap_out[79:16] == exp_f, "R7 frame unchanged", cap_out[79:16], exp_f);
        begin
            int r0;
            r0 = rise_n;
            repeat (60) @(negedge clk);
            check(busy == 0 && rise_n == r0, "R7 no second frame",
                  64'(rise_n - r0), 64'd0);
        end

        // R6 back-to-back read after a write, with the turnaround sample dropped
        run_frame(1'b1, 5'h01, 5'h1E, 16'h0000, 16'h0F0F, 1'b0);
        check(got_rd == 16'h0F0F, "R6 sample timing", 64'(got_rd), 64'h0F0F);

        finish_run();
    end
endmodule